// File: doc/BRIEF.md
# Critical-Section Selective Coherence Cache

This block is the private data cache of one core in a multicore system. It does not snoop the other caches, and no directory tracks its lines. Cores exchange data only through main memory. A core that wants its writes to reach another core places them inside a lock-protected region and tells the cache where that region begins and ends.

Outside such a region the cache runs in private mode. It is then a direct-mapped, write-back, write-allocate cache with no coherence traffic of any kind. Between the enter strobe and the exit strobe it runs in shared mode. In shared mode every line that hits or is filled is marked as tracked. The exit strobe starts a release flush, which walks the tag store once and treats only the tracked lines:
- A tracked line that is dirty is written back to memory and then invalidated.
- A tracked line that is clean is invalidated without a memory write.

The core is held off with a low ready until the walk ends. At the end a one-cycle done pulse marks the return to private mode. Lines touched only in private mode keep their state through the flush.

Top module: `cs_cache`

## Requirements
- R1: After reset, core_rdy is 1, mode_shared is 0, cs_done is 0 and mem_req is 0, and every line is invalid, so the first access to any line misses.
- R2: A read miss fetches the whole 4-word line from memory. It issues 4 reads, at word offsets 0 to 3 of the line-aligned address, and returns the addressed word. Later reads to the same line hit and cause no memory access.
- R3: A write that hits updates only the cache, so memory keeps its old value. A write that misses first fills the line from memory and then merges the written word (write-allocate).
- R4: A miss whose victim is valid and dirty writes the victim's 4 words back to memory before the fill. A miss whose victim is clean issues no memory write.
- R5: A pulse on cs_enter sets mode_shared. While mode_shared is 1, every line that hits or is filled becomes tracked.
- R6: After a pulse on cs_exit, every tracked dirty line has its 4 words written back to memory, and every tracked line is invalidated, so its next access misses.
- R7: A tracked line that is clean is invalidated without any memory write.
- R8: The flush does not change lines that were not touched while in shared mode. They stay valid and dirty, keep their data, and are not written to memory.
- R9: core_rdy is 0 from the cycle after cs_exit until the flush completes. cs_done is then a single-cycle pulse, and mode_shared is 0 after it.
- R10: Once mem_req is raised, mem_req, mem_addr and mem_we stay steady until the cycle in which mem_ack is 1. While core_rdy is 1, mem_req is 0.
- R11: Every accepted request is answered by a one-cycle core_rvalid. For a read, core_rdata carries the addressed word. For a write, core_rdata carries the word just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| core_req | input | 1 | Core request valid |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | ADDR_W | Word address: tag, then line index, then word offset |
| core_wdata | input | DATA_W | Write data |
| core_rdy | output | 1 | Request accepted on an edge where core_req and core_rdy are both 1 |
| core_rvalid | output | 1 | One-cycle response strobe |
| core_rdata | output | DATA_W | Response data |
| cs_enter | input | 1 | Strobe: enter shared mode |
| cs_exit | input | 1 | Strobe: leave shared mode and flush tracked lines |
| mode_shared | output | 1 | 1 while in shared mode |
| cs_done | output | 1 | One-cycle pulse when the release flush has finished |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = write to memory |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory accepts the request (and returns read data) this cycle |
| mem_rdata | input | DATA_W | Memory read data, valid when mem_ack is 1 |

## Verification
The bench first goes after the split between tracked and untracked lines. A flush that wrote back every dirty line would disturb memory words that the bench expects to keep their reset-time values. A flush that wrote tracked clean lines would push the write count past the exact number the bench predicts. A flush that forgot to invalidate would let a post-release read hit with no memory reads.

Evictions are tested both with dirty and with clean victims, and write-allocate is checked on the line's neighbouring words. A design with a lost write-back shows stale memory. A design with a missing fill returns wrong data for those neighbouring words.

A full 64-word sweep inside one critical section checks that the flush covers every index, including the last one. Memory acknowledges only every other cycle, so a request that drops or changes before its acknowledge is caught.

// File: rtl/cs_cache_pkg.sv
package cs_cache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_RESP,
    ST_SCAN,
    ST_FLWB,
    ST_DONE
  } cc_state_e;

  typedef struct packed {
    logic valid;
    logic dirty;
    logic touched;
  } line_flags_t;

endpackage

// File: rtl/cs_rst_sync.sv
module cs_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/cs_tag_store.sv
module cs_tag_store
  import cs_cache_pkg::*;
#(
  parameter int LINES = 16,
  parameter int TAG_W = 10,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output line_flags_t      rd_flags,
  output logic [TAG_W-1:0] rd_tag,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             acc_en,
  input  logic             acc_wr,
  input  logic             inv_en,
  input  logic             shared
);

  line_flags_t      flg_q [LINES];
  logic [TAG_W-1:0] tag_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic        sel;
    logic        upd;
    line_flags_t nxt;

    assign sel = (upd_idx == IDX_W'(g));
    assign upd = sel && (inv_en || fill_en || acc_en);

    always_comb begin
      nxt = flg_q[g];
      if (inv_en) begin
        nxt = '0;
      end else if (fill_en) begin
        nxt.valid   = 1'b1;
        nxt.dirty   = 1'b0;
        nxt.touched = shared;
      end else if (acc_en) begin
        nxt.dirty   = flg_q[g].dirty | acc_wr;
        nxt.touched = flg_q[g].touched | shared;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flg_q[g] <= '0;
      else if (upd) flg_q[g] <= nxt;
    end

    always_ff @(posedge clk) begin
      if (sel && fill_en) tag_q[g] <= fill_tag;
    end
  end

  assign rd_flags = flg_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];

endmodule

// File: rtl/cs_data_store.sv
module cs_data_store #(
  parameter int SLOTS  = 64,
  parameter int DATA_W = 32,
  localparam int SA_W  = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic [SA_W-1:0]   raddr,
  output logic [DATA_W-1:0] rdata,
  input  logic              we,
  input  logic [SA_W-1:0]   waddr,
  input  logic [DATA_W-1:0] wdata
);

  logic [DATA_W-1:0] mem_q [SLOTS];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/cs_cache.sv
module cs_cache
  import cs_cache_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_req,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              core_rdy,
  output logic              core_rvalid,
  output logic [DATA_W-1:0] core_rdata,
  input  logic              cs_enter,
  input  logic              cs_exit,
  output logic              mode_shared,
  output logic              cs_done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int IDX_W  = $clog2(LINES);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int SLOT_W = IDX_W + OFF_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORDS - 1);

  // reset release synchroniser
  logic rst_n_s;
  cs_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  // state and datapath registers
  cc_state_e         state_q, state_d;
  logic              exit_pend_q, exit_pend_d;
  logic              shared_q, shared_d;
  logic              rvalid_q, rvalid_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              req_we_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [DATA_W-1:0] req_wdata_q;
  logic [OFF_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  fidx_q, fidx_d;

  // address fields
  logic [TAG_W-1:0] c_tag, r_tag;
  logic [IDX_W-1:0] c_idx, r_idx;
  logic [OFF_W-1:0] c_off, r_off;

  assign c_tag = core_addr[ADDR_W-1 -: TAG_W];
  assign c_idx = core_addr[OFF_W +: IDX_W];
  assign c_off = core_addr[OFF_W-1:0];
  assign r_tag = req_addr_q[ADDR_W-1 -: TAG_W];
  assign r_idx = req_addr_q[OFF_W +: IDX_W];
  assign r_off = req_addr_q[OFF_W-1:0];

  // lookup and store ports
  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag;
  line_flags_t       t_flags;
  logic [TAG_W-1:0]  t_tag;
  logic              hit;
  logic              fill_en, acc_en, acc_wr, inv_en;
  logic [SLOT_W-1:0] d_raddr, d_waddr;
  logic [DATA_W-1:0] d_rdata, d_wdata;
  logic              d_we;
  logic              accept;

  always_comb begin
    unique case (state_q)
      ST_IDLE:         lk_idx = c_idx;
      ST_SCAN, ST_FLWB: lk_idx = fidx_q;
      default:         lk_idx = r_idx;
    endcase
    lk_tag = (state_q == ST_IDLE) ? c_tag : r_tag;
  end

  always_comb begin
    unique case (state_q)
      ST_IDLE: d_raddr = {c_idx, c_off};
      ST_RESP: d_raddr = {r_idx, r_off};
      ST_FLWB: d_raddr = {fidx_q, cnt_q};
      default: d_raddr = {r_idx, cnt_q};
    endcase
  end

  assign hit = t_flags.valid && (t_tag == lk_tag);

  cs_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .rd_idx   (lk_idx),
    .rd_flags (t_flags),
    .rd_tag   (t_tag),
    .upd_idx  (lk_idx),
    .fill_en  (fill_en),
    .fill_tag (r_tag),
    .acc_en   (acc_en),
    .acc_wr   (acc_wr),
    .inv_en   (inv_en),
    .shared   (shared_q)
  );

  cs_data_store #(.SLOTS(LINES * WORDS), .DATA_W(DATA_W)) u_data (
    .clk   (clk),
    .raddr (d_raddr),
    .rdata (d_rdata),
    .we    (d_we),
    .waddr (d_waddr),
    .wdata (d_wdata)
  );

  assign core_rdy    = (state_q == ST_IDLE) && !exit_pend_q;
  assign accept      = core_req && core_rdy;
  assign cs_done     = (state_q == ST_DONE);
  assign mode_shared = shared_q;
  assign core_rvalid = rvalid_q;
  assign core_rdata  = rdata_q;
  assign mem_wdata   = d_rdata;

  // next-state logic
  always_comb begin
    state_d     = state_q;
    exit_pend_d = exit_pend_q;
    shared_d    = shared_q;
    rvalid_d    = 1'b0;
    rdata_d     = rdata_q;
    cnt_d       = cnt_q;
    fidx_d      = fidx_q;
    fill_en     = 1'b0;
    acc_en      = 1'b0;
    acc_wr      = 1'b0;
    inv_en      = 1'b0;
    d_we        = 1'b0;
    d_waddr     = {r_idx, r_off};
    d_wdata     = req_wdata_q;
    mem_req     = 1'b0;
    mem_we      = 1'b0;
    mem_addr    = '0;

    unique case (state_q)
      ST_IDLE: begin
        if (exit_pend_q) begin
          state_d = ST_SCAN;
          fidx_d  = '0;
        end else if (core_req) begin
          if (hit) begin
            acc_en   = 1'b1;
            acc_wr   = core_we;
            d_we     = core_we;
            d_waddr  = {c_idx, c_off};
            d_wdata  = core_wdata;
            rvalid_d = 1'b1;
            rdata_d  = core_we ? core_wdata : d_rdata;
          end else begin
            cnt_d   = '0;
            state_d = (t_flags.valid && t_flags.dirty) ? ST_EVICT : ST_FILL;
          end
        end
      end

      ST_EVICT: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = {t_tag, r_idx, cnt_q};
        if (mem_ack) begin
          cnt_d = cnt_q + OFF_W'(1);
          if (cnt_q == LAST_OFF) begin
            cnt_d   = '0;
            state_d = ST_FILL;
          end
        end
      end

      ST_FILL: begin
        mem_req  = 1'b1;
        mem_addr = {r_tag, r_idx, cnt_q};
        if (mem_ack) begin
          d_we    = 1'b1;
          d_waddr = {r_idx, cnt_q};
          d_wdata = mem_rdata;
          cnt_d   = cnt_q + OFF_W'(1);
          if (cnt_q == LAST_OFF) begin
            fill_en = 1'b1;
            state_d = ST_RESP;
          end
        end
      end

      ST_RESP: begin
        acc_en   = 1'b1;
        acc_wr   = req_we_q;
        d_we     = req_we_q;
        d_waddr  = {r_idx, r_off};
        d_wdata  = req_wdata_q;
        rvalid_d = 1'b1;
        rdata_d  = req_we_q ? req_wdata_q : d_rdata;
        state_d  = ST_IDLE;
      end

      ST_SCAN: begin
        if (t_flags.touched && t_flags.valid && t_flags.dirty) begin
          cnt_d   = '0;
          state_d = ST_FLWB;
        end else begin
          inv_en = t_flags.touched;
          if (fidx_q == LAST_IDX) state_d = ST_DONE;
          else                    fidx_d  = fidx_q + IDX_W'(1);
        end
      end

      ST_FLWB: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = {t_tag, fidx_q, cnt_q};
        if (mem_ack) begin
          cnt_d = cnt_q + OFF_W'(1);
          if (cnt_q == LAST_OFF) begin
            inv_en = 1'b1;
            if (fidx_q == LAST_IDX) begin
              state_d = ST_DONE;
            end else begin
              fidx_d  = fidx_q + IDX_W'(1);
              state_d = ST_SCAN;
            end
          end
        end
      end

      ST_DONE: begin
        shared_d    = 1'b0;
        exit_pend_d = 1'b0;
        state_d     = ST_IDLE;
      end

      default: state_d = ST_IDLE;
    endcase

    if (cs_exit && state_q != ST_DONE) exit_pend_d = 1'b1;
    if (cs_enter && !exit_pend_q &&
        state_q != ST_SCAN && state_q != ST_FLWB && state_q != ST_DONE)
      shared_d = 1'b1;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q     <= ST_IDLE;
      exit_pend_q <= 1'b0;
      shared_q    <= 1'b0;
      rvalid_q    <= 1'b0;
    end else begin
      state_q     <= state_d;
      exit_pend_q <= exit_pend_d;
      shared_q    <= shared_d;
      rvalid_q    <= rvalid_d;
    end
  end

  // datapath registers, enables written out
  always_ff @(posedge clk) begin
    if (accept) begin
      req_we_q    <= core_we;
      req_addr_q  <= core_addr;
      req_wdata_q <= core_wdata;
    end
    if (rvalid_d) rdata_q <= rdata_d;
    cnt_q  <= cnt_d;
    fidx_q <= fidx_d;
  end

endmodule

// File: rtl/cs_cache_chk.sv
module cs_cache_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_rdy,
  input logic              cs_done,
  input logic              mode_shared,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack
);

  // R9
  done_no_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_done |-> !core_rdy);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_done |=> !cs_done);

  // R9
  done_mode_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_done |=> !mode_shared);

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R10
  mem_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rdy |-> !mem_req);

endmodule

bind cs_cache cs_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .core_rdy    (core_rdy),
  .cs_done     (cs_done),
  .mode_shared (mode_shared),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_ack     (mem_ack)
);

// File: tb/tb_cs_cache.sv
module tb_cs_cache;

  localparam int AW    = 10;
  localparam int DW    = 32;
  localparam int MEMSZ = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          core_req = 1'b0, core_we = 1'b0;
  logic [AW-1:0] core_addr = '0;
  logic [DW-1:0] core_wdata = '0;
  logic          core_rdy, core_rvalid;
  logic [DW-1:0] core_rdata;
  logic          cs_enter = 1'b0, cs_exit = 1'b0;
  logic          mode_shared, cs_done;
  logic          mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  cs_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(16), .WORDS(4)) dut (
    .clk(clk), .rst_n(rst_n),
    .core_req(core_req), .core_we(core_we), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_rdy(core_rdy), .core_rvalid(core_rvalid), .core_rdata(core_rdata),
    .cs_enter(cs_enter), .cs_exit(cs_exit), .mode_shared(mode_shared), .cs_done(cs_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] ival(input int a);
    return 32'hA500_0000 + DW'(a * 3);
  endfunction

  function automatic logic [DW-1:0] pv(input int a, input int k);
    return {8'(k), 24'h0} + 32'h0001_0000 + DW'(a);
  endfunction

  // memory model: acknowledges every other cycle
  logic [DW-1:0] bmem [MEMSZ];
  logic          gap = 1'b0;
  int            n_wr = 0, n_rd = 0;

  initial for (int i = 0; i < MEMSZ; i++) bmem[i] = ival(i);

  assign mem_ack   = mem_req & gap;
  assign mem_rdata = bmem[mem_addr];

  always @(posedge clk) begin
    gap <= ~gap;
    if (mem_req && mem_ack) begin
      if (mem_we) begin
        bmem[mem_addr] <= mem_wdata;
        n_wr <= n_wr + 1;
      end else begin
        n_rd <= n_rd + 1;
      end
    end
  end

  // request-hold monitor at the ports
  logic          pend = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic          hold_bad = 1'b0;
  always @(negedge clk) begin
    if (pend && (!mem_req || mem_addr != paddr)) hold_bad = 1'b1;
    pend  = mem_req && !mem_ack;
    paddr = mem_addr;
  end

  int errors = 0, checks = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic core_op(input bit we, input int a, input logic [DW-1:0] wd,
                         output logic [DW-1:0] rd);
    @(negedge clk);
    core_req   = 1'b1;
    core_we    = we;
    core_addr  = AW'(a);
    core_wdata = wd;
    while (!core_rdy) @(negedge clk);
    @(negedge clk);
    core_req = 1'b0;
    while (!core_rvalid) @(negedge clk);
    rd = core_rdata;
  endtask

  task automatic enter_cs();
    @(negedge clk); cs_enter = 1'b1;
    @(negedge clk); cs_enter = 1'b0;
    chk(mode_shared == 1'b1, "R5 mode_shared after enter", DW'(mode_shared), 1);
  endtask

  task automatic exit_cs(output int flush_wr);
    int  w0;
    bit  bad;
    w0  = n_wr;
    bad = 1'b0;
    @(negedge clk); cs_exit = 1'b1;
    @(negedge clk); cs_exit = 1'b0;
    while (!cs_done) begin
      if (core_rdy) bad = 1'b1;
      @(negedge clk);
    end
    chk(!bad && !core_rdy, "R9 core_rdy low during flush", DW'(bad), 0);
    @(negedge clk);
    chk(!cs_done, "R9 cs_done single pulse", DW'(cs_done), 0);
    chk(!mode_shared, "R9 mode_shared cleared", DW'(mode_shared), 0);
    flush_wr = n_wr - w0;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    int r0, w0, fw;
    bit ok;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(core_rdy == 1'b1, "R1 core_rdy", DW'(core_rdy), 1);
    chk(!mode_shared && !cs_done && !mem_req, "R1 idle outputs",
        DW'({mode_shared, cs_done, mem_req}), 0);

    // R2 / R1: every line misses first, whole line fetched
    ok = 1'b1;
    for (int a = 0; a < 64; a++) begin
      core_op(1'b0, a, '0, rd);
      if (rd != ival(a)) begin ok = 1'b0; chk(0, "R2 read miss data", rd, ival(a)); end
    end
    chk(ok, "R2 read sweep", 0, 0);
    chk(n_rd == 64, "R1 R2 line fills", DW'(n_rd), 64);
    for (int a = 0; a < 64; a++) core_op(1'b0, a, '0, rd);
    chk(n_rd == 64, "R2 hits issue no reads", DW'(n_rd), 64);

    // R3 / R11: write hits stay in cache
    ok = 1'b1;
    for (int a = 0; a < 64; a++) begin
      core_op(1'b1, a, pv(a, 1), rd);
      if (rd != pv(a, 1)) begin ok = 1'b0; chk(0, "R11 write echo", rd, pv(a, 1)); end
    end
    chk(ok, "R11 write responses", 0, 0);
    chk(n_wr == 0, "R3 no memory write on hit", DW'(n_wr), 0);
    chk(bmem[0] == ival(0), "R3 memory keeps old value", bmem[0], ival(0));
    ok = 1'b1;
    for (int a = 0; a < 64; a++) begin
      core_op(1'b0, a, '0, rd);
      if (rd != pv(a, 1)) begin ok = 1'b0; chk(0, "R3 read back", rd, pv(a, 1)); end
    end
    chk(ok, "R3 read back sweep", 0, 0);

    // R3 write-allocate with dirty victim (R4)
    core_op(1'b1, 68, pv(68, 7), rd);
    chk(n_wr == 4, "R4 dirty victim written back", DW'(n_wr), 4);
    chk(n_rd == 68, "R3 write miss fills line", DW'(n_rd), 68);
    ok = 1'b1;
    for (int a = 4; a < 8; a++) if (bmem[a] != pv(a, 1)) ok = 1'b0;
    chk(ok, "R4 victim data in memory", bmem[4], pv(4, 1));
    core_op(1'b0, 69, '0, rd);
    chk(rd == ival(69), "R3 allocated neighbour word", rd, ival(69));
    core_op(1'b0, 68, '0, rd);
    chk(rd == pv(68, 7), "R3 merged word", rd, pv(68, 7));

    // R4 clean victim
    core_op(1'b0, 72, '0, rd);
    chk(n_wr == 8, "R4 dirty line 2 written back", DW'(n_wr), 8);
    core_op(1'b0, 136, '0, rd);
    chk(n_wr == 8, "R4 clean victim no write", DW'(n_wr), 8);
    chk(rd == ival(136), "R2 read after clean evict", rd, ival(136));

    // R5..R8: critical section with mixed lines
    enter_cs();
    core_op(1'b0, 12, '0, rd);            // line 3 tag0 dirty: tracked dirty
    core_op(1'b1, 144, pv(144, 2), rd);   // line 4: evict dirty, fill, write
    chk(n_wr == 12, "R4 eviction inside section", DW'(n_wr), 12);
    core_op(1'b0, 136, '0, rd);           // line 2 tag2 clean: tracked clean
    exit_cs(fw);
    chk(fw == 8, "R6 R7 flush writes only tracked dirty", DW'(fw), 8);
    ok = 1'b1;
    for (int a = 12; a < 16; a++) if (bmem[a] != pv(a, 1)) ok = 1'b0;
    chk(ok, "R6 tracked dirty line written", bmem[12], pv(12, 1));
    chk(bmem[144] == pv(144, 2), "R6 tracked written word", bmem[144], pv(144, 2));
    chk(bmem[145] == ival(145), "R6 tracked unwritten word", bmem[145], ival(145));
    chk(bmem[68] == ival(68), "R8 untracked dirty line kept", bmem[68], ival(68));
    chk(bmem[20] == ival(20), "R8 untracked line 5 kept", bmem[20], ival(20));
    r0 = n_rd;
    core_op(1'b0, 12, '0, rd);
    chk(n_rd == r0 + 4 && rd == pv(12, 1), "R6 tracked line invalidated", DW'(n_rd - r0), 4);
    r0 = n_rd;
    core_op(1'b0, 136, '0, rd);
    chk(n_rd == r0 + 4, "R7 tracked clean line invalidated", DW'(n_rd - r0), 4);
    r0 = n_rd;
    core_op(1'b0, 20, '0, rd);
    chk(n_rd == r0 && rd == pv(20, 1), "R8 untracked line still hits", rd, pv(20, 1));

    // R6 full sweep inside one section, covers every index
    enter_cs();
    for (int a = 320; a < 384; a++) core_op(1'b1, a, pv(a, 3), rd);
    w0 = n_wr;
    exit_cs(fw);
    chk(fw == 64, "R6 sweep flush writes", DW'(fw), 64);
    ok = 1'b1;
    for (int a = 320; a < 384; a++)
      if (bmem[a] != pv(a, 3)) begin ok = 1'b0; chk(0, "R6 sweep memory", bmem[a], pv(a, 3)); end
    chk(ok, "R6 sweep memory image", 0, 0);
    r0 = n_rd;
    ok = 1'b1;
    for (int a = 320; a < 384; a++) begin
      core_op(1'b0, a, '0, rd);
      if (rd != pv(a, 3)) ok = 1'b0;
    end
    chk(ok && n_rd == r0 + 64, "R6 all lines refetched", DW'(n_rd - r0), 64);
    chk(w0 >= 0 && !hold_bad, "R10 memory request held until ack", DW'(hold_bad), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule